// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block makes a user clock output from a fixed reference clock of about 25 MHz. The division factor is an integer from a 5-bit field. A setting of 0 or 1 sends the reference itself to the output. A setting of 2 to 31 divides the reference by that number. Software writes the factor together with an invert flag, a symmetric-duty flag and a write-1 clear strobe. The write arrives on a write strobe that is already registered. The output is gated by an external enable input. An idle flag shows whether a divided period is still running.

Changes are meant to be glitch-free. A new factor, or a drop of the enable, waits until the period in progress has finished. The clear strobe ends the period at once. A factor written in the same access as the clear starts on the next cycle. Inversion is the last stage of the output path, so the resting level is 0 without inversion and 1 with it. When symmetric mode is on, a flop on the falling reference edge moves the rising output edge by half a reference cycle, so an odd factor gives an even duty cycle.

Top module: `clkout_divider`

## Requirements
- R1: With a factor of 0 or 1 and the enable high, the output follows the reference: high during each reference high phase and low during each low phase. The output shows one rising edge per reference cycle.
- R2: With a factor N from 2 to 31 and symmetric mode off, each output period lasts N reference cycles. The output is low for floor(N/2) cycles and then high for ceil(N/2) cycles.
- R3: With symmetric mode on and an odd factor N, high and low each last N reference half-cycles. With an even factor the waveform is the same as in R2.
- R4: A factor written while a period is running leaves that period unchanged. The new factor governs the next period.
- R5: When the enable drops during a period, that period runs to its end. The divider then stops, and the output rests at its idle level.
- R6: A write with the clear strobe set stops the divider at that same clock edge, forces the pre-inversion output to 0 and raises the idle flag. If the enable is high, a new period starts on the following edge, using the factor written in that access.
- R7: The invert flag XORs the final output. It takes effect in the cycle after its write, so a stopped output rests at 1 while the flag is set.
- R8: The idle flag is 1 whenever no divided period (factor 2 or more) is running, and this includes pass-through mode. It is 0 while such a period runs.
- R9: When the divider starts from idle, the first period begins with its low portion, using the factor held at that edge.
- R10: An active-low asynchronous reset stops the divider and clears the factor, the invert flag and the symmetric flag to 0. The output is then 0 and the idle flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| out_en | input | 1 | Output enable; periods continue while high |
| ctl_wr | input | 1 | Registered write strobe for the control fields |
| ctl_clr | input | 1 | Write-1 clear, acted on only together with ctl_wr |
| ctl_div | input | 5 | Division factor (0 and 1 pass the reference through) |
| ctl_inv | input | 1 | Output inversion flag |
| ctl_sym | input | 1 | Symmetric-duty flag for odd factors |
| clk_out | output | 1 | Generated clock output |
| idle | output | 1 | 1 when no divided period is in progress |

## Verification
The assertions check the divider state on every cycle. A clear stops it at once. The latched factor stays fixed until a period boundary. A period started from idle begins low. A period that has not reached its last cycle is never cut short, unless a clear arrives. A dropped enable stops the divider exactly at the boundary. Pass-through never overlaps a divided period. The output shape needs the bench scenarios, which sample both phases of every reference cycle: the duty counts for each factor, the half-cycle offset of symmetric mode, inversion, and the waveform of the pass-through path.

// File: rtl/clkout_div_pkg.sv
package clkout_div_pkg;

    localparam int unsigned DIV_W_DEFAULT = 5;

    typedef struct packed {
        logic inv;
        logic sym;
    } shape_cfg_t;

endpackage

// File: rtl/clkout_div_cfg.sv
module clkout_div_cfg #(
    parameter int unsigned DIV_W = clkout_div_pkg::DIV_W_DEFAULT
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_i,
    input  logic                             clr_i,
    input  logic [DIV_W-1:0]                 div_i,
    input  logic                             inv_i,
    input  logic                             sym_i,
    output logic [DIV_W-1:0]                 div_o,
    output clkout_div_pkg::shape_cfg_t       shape_o,
    output logic                             clear_o
);
    import clkout_div_pkg::*;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        shape_cfg_t       shape;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            cfg_d.div       = div_i;
            cfg_d.shape.inv = inv_i;
            cfg_d.shape.sym = sym_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign div_o   = cfg_q.div;
    assign shape_o = cfg_q.shape;
    // the clear is taken into the divider state registers on the write edge
    assign clear_o = wr_i & clr_i;

endmodule

// File: rtl/clkout_div_core.sv
module clkout_div_core #(
    parameter int unsigned DIV_W = clkout_div_pkg::DIV_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             clr_i,
    output logic             run_o,
    output logic [DIV_W-1:0] cnt_o,
    output logic [DIV_W-1:0] act_o,
    output logic             dout_o,
    output logic             pass_o
);

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] act;
        logic             dout;
        logic             pass;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        divides;
    logic        start_ok;
    logic        last_cyc;

    always_comb begin
        divides  = (div_i >> 1) != '0;
        start_ok = en_i && divides;
        last_cyc = st_q.cnt == (st_q.act - 1'b1);
        st_d     = st_q;
        if (clr_i) begin
            st_d.run  = 1'b0;
            st_d.cnt  = '0;
            st_d.dout = 1'b0;
            st_d.pass = 1'b0;
        end else begin
            if (st_q.run) begin
                if (last_cyc) begin
                    st_d.cnt = '0;
                    st_d.run = start_ok;
                    if (start_ok) begin
                        st_d.act = div_i;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else if (start_ok) begin
                st_d.run = 1'b1;
                st_d.act = div_i;
                st_d.cnt = '0;
            end
            // low for floor(N/2) cycles, then high for the rest
            st_d.dout = st_d.run && (st_d.cnt >= (st_d.act >> 1));
            st_d.pass = en_i && !st_d.run && !divides;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o  = st_q.run;
    assign cnt_o  = st_q.cnt;
    assign act_o  = st_q.act;
    assign dout_o = st_q.dout;
    assign pass_o = st_q.pass;

endmodule

// File: rtl/clkout_div_shape.sv
module clkout_div_shape (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pass_i,
    input  logic                       dout_i,
    input  logic                       odd_i,
    input  clkout_div_pkg::shape_cfg_t cfg_i,
    output logic                       clk_out_o
);

    typedef struct packed {
        logic gate;
        logic dly;
    } neg_state_t;

    neg_state_t neg_d, neg_q;
    logic       sym_sel;
    logic       div_wave;
    logic       pre_inv;

    always_comb begin
        neg_d.gate = pass_i;
        neg_d.dly  = dout_i;
    end

    // falling-edge flops: glitch-free pass gate and half-cycle delayed copy
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q <= '0;
        end else begin
            neg_q <= neg_d;
        end
    end

    always_comb begin
        sym_sel   = cfg_i.sym & odd_i;
        div_wave  = sym_sel ? (dout_i & neg_q.dly) : dout_i;
        pre_inv   = (clk & neg_q.gate) | div_wave;
        clk_out_o = pre_inv ^ cfg_i.inv;
    end

endmodule

// File: rtl/clkout_divider.sv
module clkout_divider #(
    parameter int unsigned DIV_W = clkout_div_pkg::DIV_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_en,
    input  logic             ctl_wr,
    input  logic             ctl_clr,
    input  logic [DIV_W-1:0] ctl_div,
    input  logic             ctl_inv,
    input  logic             ctl_sym,
    output logic             clk_out,
    output logic             idle
);
    import clkout_div_pkg::*;

    logic [DIV_W-1:0] cfg_div;
    shape_cfg_t       cfg_shape;
    logic             cfg_clear;
    logic             core_run;
    logic [DIV_W-1:0] core_cnt;
    logic [DIV_W-1:0] core_act;
    logic             core_dout;
    logic             core_pass;

    clkout_div_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr),
        .clr_i   (ctl_clr),
        .div_i   (ctl_div),
        .inv_i   (ctl_inv),
        .sym_i   (ctl_sym),
        .div_o   (cfg_div),
        .shape_o (cfg_shape),
        .clear_o (cfg_clear)
    );

    clkout_div_core #(.DIV_W(DIV_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (out_en),
        .div_i  (cfg_div),
        .clr_i  (cfg_clear),
        .run_o  (core_run),
        .cnt_o  (core_cnt),
        .act_o  (core_act),
        .dout_o (core_dout),
        .pass_o (core_pass)
    );

    clkout_div_shape u_shape (
        .clk       (clk),
        .rst_n     (rst_n),
        .pass_i    (core_pass),
        .dout_i    (core_dout),
        .odd_i     (core_act[0]),
        .cfg_i     (cfg_shape),
        .clk_out_o (clk_out)
    );

    assign idle = !core_run;

endmodule

// File: rtl/clkout_divider_chk.sv
module clkout_divider_chk #(
    parameter int unsigned DIV_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_en,
    input logic             ctl_wr,
    input logic             ctl_clr,
    input logic             idle,
    input logic             run,
    input logic [DIV_W-1:0] cnt,
    input logic [DIV_W-1:0] act,
    input logic             dout,
    input logic             pass
);

    p_clear_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_clr) |=> (idle && !dout));

    p_factor_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (cnt != act - 1'b1)) |=> $stable(act));

    p_start_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (!dout && cnt == '0));

    p_graceful_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !out_en && (cnt == act - 1'b1) && !(ctl_wr && ctl_clr)) |=> idle);

    p_no_early_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (cnt != act - 1'b1) && !(ctl_wr && ctl_clr)) |=> !idle);

    p_pass_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> idle);

    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !dout);

endmodule

bind clkout_divider clkout_divider_chk #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .out_en  (out_en),
    .ctl_wr  (ctl_wr),
    .ctl_clr (ctl_clr),
    .idle    (idle),
    .run     (core_run),
    .cnt     (core_cnt),
    .act     (core_act),
    .dout    (core_dout),
    .pass    (core_pass)
);

// File: tb/clkout_divider_bench.sv
module clkout_divider_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       out_en;
    logic       ctl_wr;
    logic       ctl_clr;
    logic [4:0] ctl_div;
    logic       ctl_inv;
    logic       ctl_sym;
    logic       clk_out;
    logic       idle;

    logic s_hi, s_lo, s_idle;
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    clkout_divider u_clkout_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .out_en  (out_en),
        .ctl_wr  (ctl_wr),
        .ctl_clr (ctl_clr),
        .ctl_div (ctl_div),
        .ctl_inv (ctl_inv),
        .ctl_sym (ctl_sym),
        .clk_out (clk_out),
        .idle    (idle)
    );

    // factor, symmetric, invert, period in cycles, high half-cycle samples per period
    typedef struct packed {
        logic [4:0] div;
        logic       sym;
        logic       inv;
        logic [5:0] per;
        logic [6:0] highs;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{5'd0,  1'b0, 1'b0, 6'd1,  7'd1},
        '{5'd1,  1'b0, 1'b0, 6'd1,  7'd1},
        '{5'd1,  1'b1, 1'b1, 6'd1,  7'd1},
        '{5'd2,  1'b0, 1'b0, 6'd2,  7'd2},
        '{5'd3,  1'b0, 1'b0, 6'd3,  7'd4},
        '{5'd3,  1'b1, 1'b0, 6'd3,  7'd3},
        '{5'd5,  1'b0, 1'b1, 6'd5,  7'd4},
        '{5'd5,  1'b1, 1'b0, 6'd5,  7'd5},
        '{5'd8,  1'b1, 1'b0, 6'd8,  7'd8},
        '{5'd8,  1'b0, 1'b1, 6'd8,  7'd8},
        '{5'd31, 1'b0, 1'b0, 6'd31, 7'd32},
        '{5'd31, 1'b1, 1'b1, 6'd31, 7'd31},
        '{5'd7,  1'b0, 1'b0, 6'd7,  7'd8}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one reference cycle: sample high phase, low phase, end just before the next edge
    task automatic cyc();
        @(posedge clk);
        #2;
        s_hi   = clk_out;
        s_idle = idle;
        #5;
        s_lo = clk_out;
        #1;
    endtask

    task automatic wr(input logic clr, input logic [4:0] div, input logic sym, input logic inv);
        ctl_wr  = 1'b1;
        ctl_clr = clr;
        ctl_div = div;
        ctl_sym = sym;
        ctl_inv = inv;
        cyc();
        ctl_wr  = 1'b0;
        ctl_clr = 1'b0;
    endtask

    task automatic wait_rise();
        logic prev;
        prev = s_lo;
        for (int i = 0; i < 100; i++) begin
            cyc();
            if (!prev && s_lo) break;
            prev = s_lo;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        rst_n   = 1'b0;
        out_en  = 1'b0;
        ctl_wr  = 1'b0;
        ctl_clr = 1'b0;
        ctl_div = '0;
        ctl_inv = 1'b0;
        ctl_sym = 1'b0;
        #23;
        // R10: reset state
        check("R10", "clk_out in reset", int'(clk_out), 0);
        check("R10", "idle in reset", int'(idle), 1);
        @(posedge clk);
        #8;
        rst_n = 1'b1;
        cyc();
        check("R10", "clk_out after reset", int'(s_hi | s_lo), 0);

        // vector table: duty and period for each factor and mode
        out_en = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            int    highs;
            int    rises;
            logic  prev;
            string tag;
            wr(1'b1, VEC[v].div, VEC[v].sym, VEC[v].inv);
            repeat (3 * int'(VEC[v].per) + 3) cyc();
            prev  = s_lo;
            highs = 0;
            rises = 0;
            for (int c = 0; c < 4 * int'(VEC[v].per); c++) begin
                cyc();
                highs += int'(s_hi) + int'(s_lo);
                if (!prev && s_hi) rises++;
                if (!s_hi && s_lo) rises++;
                prev = s_lo;
            end
            if (VEC[v].per == 6'd1)                      tag = "R1";
            else if (VEC[v].sym && VEC[v].div[0])        tag = "R3";
            else if (VEC[v].inv)                         tag = "R7";
            else                                         tag = "R2";
            check(tag, $sformatf("high samples div=%0d", VEC[v].div), highs, 4 * int'(VEC[v].highs));
            check(tag, $sformatf("rising edges div=%0d", VEC[v].div), rises, 4);
        end

        // R4: factor change mid-period waits for the boundary
        wr(1'b1, 5'd4, 1'b0, 1'b0);
        wait_rise();
        wr(1'b0, 5'd8, 1'b0, 1'b0);
        check("R4", "old period still high", int'(s_lo), 1);
        for (int k = 0; k < 9; k++) begin
            cyc();
            check("R4", $sformatf("new period cycle %0d", k), int'(s_lo), (k >= 4 && k < 8) ? 1 : 0);
        end

        // R5: disable completes the period in progress
        wr(1'b1, 5'd6, 1'b0, 1'b0);
        wait_rise();
        out_en = 1'b0;
        cyc();
        check("R5", "high continues 1", int'(s_lo), 1);
        check("R8", "busy while running", int'(s_idle), 0);
        cyc();
        check("R5", "high continues 2", int'(s_lo), 1);
        cyc();
        check("R5", "stopped low", int'(s_lo), 0);
        check("R5", "idle after stop", int'(s_idle), 1);
        repeat (3) cyc();
        check("R5", "stays at rest", int'(s_hi | s_lo), 0);

        // R7: inversion acts at once, rest level 1
        wr(1'b0, 5'd6, 1'b0, 1'b1);
        check("R7", "inverted rest high phase", int'(s_hi), 1);
        check("R7", "inverted rest low phase", int'(s_lo), 1);
        wr(1'b0, 5'd5, 1'b0, 1'b0);
        check("R7", "rest back to 0", int'(s_lo), 0);

        // R9: start from idle begins low with latched factor 5
        out_en = 1'b1;
        cyc();
        check("R9", "idle drops at start", int'(s_idle), 0);
        check("R9", "first cycle low", int'(s_lo), 0);
        cyc();
        check("R9", "second cycle low", int'(s_lo), 0);
        cyc();
        check("R9", "third cycle high", int'(s_lo), 1);

        // R6: clear with new factor aborts period and restarts
        wr(1'b1, 5'd3, 1'b0, 1'b0);
        check("R6", "idle on clear", int'(s_idle), 1);
        check("R6", "output 0 on clear", int'(s_hi | s_lo), 0);
        cyc();
        check("R6", "restart busy", int'(s_idle), 0);
        check("R6", "restart low", int'(s_lo), 0);
        cyc();
        check("R6", "factor 3 high 1", int'(s_lo), 1);
        cyc();
        check("R6", "factor 3 high 2", int'(s_lo), 1);
        cyc();
        check("R6", "factor 3 next low", int'(s_lo), 0);

        // R8: idle reads 1 in pass-through mode while the output toggles
        wr(1'b1, 5'd1, 1'b0, 1'b0);
        repeat (3) cyc();
        check("R8", "idle in pass mode", int'(s_idle), 1);
        check("R1", "pass high phase", int'(s_hi), 1);
        check("R1", "pass low phase", int'(s_lo), 0);

        finish_run();
    end

endmodule